// File: doc/BRIEF.md
# Weighted Switching Activity Meter

This block estimates how much switching a monitored circuit does while a scan test runs. On every sampled cycle it compares a bus of combinational gate outputs with the values seen on the previous sampled cycle. Each node that toggled adds its load weight to the cycle's figure. A node's load weight is its fan-out count, and it is supplied as a parameter. Every scan cell also adds a fixed charge: a small one when its input held, a larger one when its input toggled.

The per-cycle figure comes out of a register together with a valid flag. The block also keeps a running total and a count of the sampled cycles. An average is the running total divided by the cycle count, and the user forms it outside the block. A synchronous clear starts a new measurement. If the total cannot hold another addition, it saturates and a sticky flag is raised.

Top module: `toggle_cost_meter`

## Requirements
- R1: When node i (bit i of `node_val`) differs from its previous sampled value, the cycle figure includes that node's weight. The weight is field `NODE_WEIGHTS[i*WW +: WW]`.
- R2: A node whose value equals its previous sampled value adds nothing to the cycle figure.
- R3: A scan cell (bit j of `scan_val`) whose value equals its previous sampled value adds `SCAN_HOLD_COST` (default 2).
- R4: A scan cell whose value differs from its previous sampled value adds `SCAN_FLIP_COST` (default 6).
- R5: After reset, and after a clear, every stored previous value of nodes and scan cells is 0.
- R6: With `sample_en` high and `clr` low at a rising edge, `cyc_cost` and `cyc_valid` = 1 appear right after that edge. With `sample_en` low, `cyc_valid` is 0 after the edge and the stored previous values are kept.
- R7: Each sampled cycle adds its figure to `total_cost` and adds 1 to `cyc_count`, both at the same edge as the figure. Unsampled cycles change neither.
- R8: `clr` high at an edge zeroes `total_cost`, `cyc_count`, `cyc_cost`, `cyc_valid`, `ovf` and the stored previous values. `clr` takes priority over `sample_en`.
- R9: If an addition would carry out of `total_cost`, the total holds at all ones and `ovf` goes to 1 and stays there until a clear. A cycle count that would wrap does the same.
- R10: While reset is asserted and right after it is released, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the measurement |
| sample_en | input | 1 | Marks a cycle to be counted |
| node_val | input | N_NODES | Monitored combinational outputs |
| scan_val | input | N_CELLS | Monitored scan cell inputs |
| cyc_cost | output | COST_W | Figure for the last sampled cycle |
| cyc_valid | output | 1 | `cyc_cost` belongs to the previous edge |
| total_cost | output | TOT_W | Accumulated figure |
| cyc_count | output | CNT_W | Number of sampled cycles |
| ovf | output | 1 | Sticky saturation flag |

## Verification
Every result is one register stage deep. The figure, the valid flag, the total, the count and the flag all change at the edge that samples the inputs. Inputs are driven on the falling edge, and the outputs are compared on the next falling edge, half a period after they update. For a clear, the zeroed values are due one edge after it. The first sample after the clear is then compared against previous values of zero.

// File: rtl/tcm_pkg.sv
package tcm_pkg;

  // Width that holds the largest possible figure of one cycle
  function automatic int cost_width(int n_nodes, int ww, int n_cells, int flip_cost);
    int max_cost;
    max_cost = n_nodes * ((1 << ww) - 1) + n_cells * flip_cost;
    return $clog2(max_cost + 1);
  endfunction

endpackage

// File: rtl/tcm_node_cost.sv
module tcm_node_cost #(
  parameter int N_NODES = 8,
  parameter int WW      = 4,
  parameter logic [N_NODES*WW-1:0] NODE_WEIGHTS = '0,
  parameter int COST_W  = 8
) (
  input  logic [N_NODES-1:0] cur_val,
  input  logic [N_NODES-1:0] old_val,
  output logic [COST_W-1:0]  cost
);

  logic [WW-1:0] node_charge [N_NODES];

  // One masked weight for each node
  for (genvar g = 0; g < N_NODES; g++) begin : g_node
    assign node_charge[g] = (cur_val[g] ^ old_val[g]) ? NODE_WEIGHTS[g*WW +: WW] : '0;
  end

  always_comb begin
    cost = '0;
    for (int i = 0; i < N_NODES; i++) begin
      cost = cost + COST_W'(node_charge[i]);
    end
  end

endmodule

// File: rtl/tcm_scan_cost.sv
module tcm_scan_cost #(
  parameter int N_CELLS   = 4,
  parameter int HOLD_COST = 2,
  parameter int FLIP_COST = 6,
  parameter int COST_W    = 8
) (
  input  logic [N_CELLS-1:0] cur_val,
  input  logic [N_CELLS-1:0] old_val,
  output logic [COST_W-1:0]  cost
);

  localparam logic [COST_W-1:0] HOLD_V = COST_W'(HOLD_COST);
  localparam logic [COST_W-1:0] FLIP_V = COST_W'(FLIP_COST);

  logic [COST_W-1:0] cell_charge [N_CELLS];

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    assign cell_charge[g] = (cur_val[g] ^ old_val[g]) ? FLIP_V : HOLD_V;
  end

  always_comb begin
    cost = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      cost = cost + cell_charge[i];
    end
  end

endmodule

// File: rtl/tcm_accum.sv
module tcm_accum #(
  parameter int COST_W = 8,
  parameter int TOT_W  = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              sample_en,
  input  logic [COST_W-1:0] cost_in,
  output logic [COST_W-1:0] cyc_cost,
  output logic              cyc_valid,
  output logic [TOT_W-1:0]  total_cost,
  output logic [CNT_W-1:0]  cyc_count,
  output logic              ovf
);

  localparam logic [TOT_W-1:0] TOT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [COST_W-1:0] cost_d;
  logic              valid_d;
  logic [TOT_W-1:0]  total_d;
  logic [CNT_W-1:0]  count_d;
  logic              ovf_d;
  logic [TOT_W:0]    sum_ext;

  assign sum_ext = {1'b0, total_cost} + (TOT_W+1)'(cost_in);

  always_comb begin
    cost_d  = cyc_cost;
    valid_d = 1'b0;
    total_d = total_cost;
    count_d = cyc_count;
    ovf_d   = ovf;
    if (clr) begin
      cost_d  = '0;
      total_d = '0;
      count_d = '0;
      ovf_d   = 1'b0;
    end else if (sample_en) begin
      cost_d  = cost_in;
      valid_d = 1'b1;
      if (sum_ext[TOT_W]) begin
        total_d = TOT_MAX;
        ovf_d   = 1'b1;
      end else begin
        total_d = sum_ext[TOT_W-1:0];
      end
      if (cyc_count == CNT_MAX) begin
        ovf_d = 1'b1;
      end else begin
        count_d = cyc_count + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_cost   <= '0;
      cyc_valid  <= 1'b0;
      total_cost <= '0;
      cyc_count  <= '0;
      ovf        <= 1'b0;
    end else begin
      cyc_cost   <= cost_d;
      cyc_valid  <= valid_d;
      total_cost <= total_d;
      cyc_count  <= count_d;
      ovf        <= ovf_d;
    end
  end

endmodule

// File: rtl/toggle_cost_meter.sv
module toggle_cost_meter #(
  parameter int N_NODES = 8,
  parameter int WW      = 4,
  parameter logic [N_NODES*WW-1:0] NODE_WEIGHTS = 32'h3124_1321,
  parameter int N_CELLS = 4,
  parameter int SCAN_HOLD_COST = 2,
  parameter int SCAN_FLIP_COST = 6,
  parameter int TOT_W   = 32,
  parameter int CNT_W   = 24,
  parameter int COST_W  = tcm_pkg::cost_width(N_NODES, WW, N_CELLS, SCAN_FLIP_COST)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               sample_en,
  input  logic [N_NODES-1:0] node_val,
  input  logic [N_CELLS-1:0] scan_val,
  output logic [COST_W-1:0]  cyc_cost,
  output logic               cyc_valid,
  output logic [TOT_W-1:0]   total_cost,
  output logic [CNT_W-1:0]   cyc_count,
  output logic               ovf
);

  logic [N_NODES-1:0] node_old, node_old_d;
  logic [N_CELLS-1:0] scan_old, scan_old_d;
  logic [COST_W-1:0]  node_part;
  logic [COST_W-1:0]  scan_part;
  logic [COST_W-1:0]  step_cost;

  tcm_node_cost #(
    .N_NODES(N_NODES), .WW(WW), .NODE_WEIGHTS(NODE_WEIGHTS), .COST_W(COST_W)
  ) node_cost_i (
    .cur_val(node_val), .old_val(node_old), .cost(node_part)
  );

  tcm_scan_cost #(
    .N_CELLS(N_CELLS), .HOLD_COST(SCAN_HOLD_COST), .FLIP_COST(SCAN_FLIP_COST),
    .COST_W(COST_W)
  ) scan_cost_i (
    .cur_val(scan_val), .old_val(scan_old), .cost(scan_part)
  );

  assign step_cost = node_part + scan_part;

  tcm_accum #(
    .COST_W(COST_W), .TOT_W(TOT_W), .CNT_W(CNT_W)
  ) accum_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sample_en(sample_en),
    .cost_in(step_cost), .cyc_cost(cyc_cost), .cyc_valid(cyc_valid),
    .total_cost(total_cost), .cyc_count(cyc_count), .ovf(ovf)
  );

  // Previous-value store: next state
  always_comb begin
    node_old_d = node_old;
    scan_old_d = scan_old;
    if (clr) begin
      node_old_d = '0;
      scan_old_d = '0;
    end else if (sample_en) begin
      node_old_d = node_val;
      scan_old_d = scan_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_old <= '0;
      scan_old <= '0;
    end else begin
      node_old <= node_old_d;
      scan_old <= scan_old_d;
    end
  end

endmodule

// File: rtl/tcm_checker.sv
module tcm_checker #(
  parameter int N_CELLS = 4,
  parameter int SCAN_HOLD_COST = 2,
  parameter int TOT_W  = 32,
  parameter int CNT_W  = 24,
  parameter int COST_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              sample_en,
  input logic [COST_W-1:0] cyc_cost,
  input logic              cyc_valid,
  input logic [TOT_W-1:0]  total_cost,
  input logic [CNT_W-1:0]  cyc_count,
  input logic              ovf
);

  // R6
  valid_follows_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> $past(sample_en && !clr));

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !clr && !ovf) |=> (ovf || (cyc_count == $past(cyc_count) + CNT_W'(1))));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_en && !clr) |=> ($stable(total_cost) && $stable(cyc_count) && !cyc_valid));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (total_cost == '0 && cyc_count == '0 && !ovf && !cyc_valid));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);

  // R3
  scan_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_valid |-> (int'(cyc_cost) >= N_CELLS * SCAN_HOLD_COST));

endmodule

bind toggle_cost_meter tcm_checker #(
  .N_CELLS(N_CELLS), .SCAN_HOLD_COST(SCAN_HOLD_COST),
  .TOT_W(TOT_W), .CNT_W(CNT_W), .COST_W(COST_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .clr(clr), .sample_en(sample_en),
  .cyc_cost(cyc_cost), .cyc_valid(cyc_valid), .total_cost(total_cost),
  .cyc_count(cyc_count), .ovf(ovf)
);

// File: tb/toggle_cost_meter_tb_top.sv
`timescale 1ns/1ps
module toggle_cost_meter_tb_top;

  localparam int NN = 8;
  localparam int WW = 4;
  localparam int NC = 4;
  localparam logic [NN*WW-1:0] WGT = 32'h3124_1321;
  localparam int TW = 12;
  localparam int CW = 10;
  localparam int KW = tcm_pkg::cost_width(NN, WW, NC, 6);

  logic clk, rst_n, clr, sample_en;
  logic [NN-1:0] node_val;
  logic [NC-1:0] scan_val;
  logic [KW-1:0] cyc_cost;
  logic          cyc_valid;
  logic [TW-1:0] total_cost;
  logic [CW-1:0] cyc_count;
  logic          ovf;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  int m_pn, m_pc, m_tot, m_cnt, m_cost, m_valid, m_ovf;

  toggle_cost_meter #(
    .N_NODES(NN), .WW(WW), .NODE_WEIGHTS(WGT), .N_CELLS(NC),
    .TOT_W(TW), .CNT_W(CW)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .sample_en(sample_en),
    .node_val(node_val), .scan_val(scan_val), .cyc_cost(cyc_cost),
    .cyc_valid(cyc_valid), .total_cost(total_cost), .cyc_count(cyc_count),
    .ovf(ovf)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {nodes[7:0], cells[3:0]}
  localparam logic [11:0] VEC [8] = '{12'h000, 12'h011, 12'h031, 12'h0F0,
                                      12'hF0F, 12'hF0F, 12'h80A, 12'hFF5};

  function automatic int ref_cost(int n, int c, int pn, int pc);
    int s = 0;
    for (int i = 0; i < NN; i++)
      if (((n >> i) & 1) != ((pn >> i) & 1)) s += int'(WGT[i*WW +: WW]);  // R1, R2
    for (int j = 0; j < NC; j++)
      s += (((c >> j) & 1) != ((pc >> j) & 1)) ? 6 : 2;                   // R3, R4
    return s;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check({req, " cyc_cost"}, int'(cyc_cost), m_cost);
    check({req, " cyc_valid"}, int'(cyc_valid), m_valid);
    check({req, " total_cost"}, int'(total_cost), m_tot);
    check({req, " cyc_count"}, int'(cyc_count), m_cnt);
    check({req, " ovf"}, int'(ovf), m_ovf);
  endtask

  // drive at falling edge, the rising edge samples, compare at the next falling edge
  task automatic step(bit en, bit cl, int n, int c);
    sample_en = en; clr = cl;
    node_val = NN'(n); scan_val = NC'(c);
    @(negedge clk);
    if (cl) begin
      m_pn = 0; m_pc = 0; m_tot = 0; m_cnt = 0; m_cost = 0; m_valid = 0; m_ovf = 0;
    end else if (en) begin
      m_cost = ref_cost(n, c, m_pn, m_pc);
      m_valid = 1;
      if (m_tot + m_cost > (1 << TW) - 1) begin m_tot = (1 << TW) - 1; m_ovf = 1; end
      else m_tot = m_tot + m_cost;
      if (m_cnt == (1 << CW) - 1) m_ovf = 1; else m_cnt++;
      m_pn = n; m_pc = c;
    end else begin
      m_valid = 0;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; clr = 1'b0; sample_en = 1'b0; node_val = '0; scan_val = '0;
    m_pn = 0; m_pc = 0; m_tot = 0; m_cnt = 0; m_cost = 0; m_valid = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    check_all("R10 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R10 after release");

    // table walk: R1 R2 R3 R4 R5 R6 R7
    for (int k = 0; k < 8; k++) begin
      step(1'b1, 1'b0, int'(VEC[k][11:4]), int'(VEC[k][3:0]));
      check_all("R1/R2/R3/R4/R7 vector");
    end

    // idle cycle keeps totals and previous values (R6, R7)
    step(1'b0, 1'b0, 8'h00, 4'h0);
    check_all("R6 idle");
    step(1'b1, 1'b0, int'(VEC[7][11:4]), int'(VEC[7][3:0]));
    check("R6 held previous values", int'(cyc_cost), 8);

    // clear takes priority over sample (R8), previous values back to zero (R5)
    step(1'b1, 1'b1, 8'hFF, 4'hF);
    check_all("R8 clear");
    step(1'b1, 1'b0, 8'h01, 4'h0);
    check("R5 zero after clear", int'(cyc_cost), 9);
    check_all("R5 state");

    // saturation (R9): 41 per cycle
    for (int k = 0; k < 120; k++) begin
      step(1'b1, 1'b0, (k % 2 == 0) ? 8'h00 : 8'hFF, (k % 2 == 0) ? 4'hF : 4'h0);
    end
    check("R9 total saturated", int'(total_cost), (1 << TW) - 1);
    check("R9 ovf raised", int'(ovf), 1);
    step(1'b0, 1'b0, 8'h00, 4'h0);
    check("R9 ovf sticky", int'(ovf), 1);
    check_all("R9 state");
    step(1'b0, 1'b1, 8'h00, 4'h0);
    check_all("R8 clear after saturation");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule